// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Multiplier

This block multiplies two IEEE 754 binary32 numbers over several clock cycles under the control of a finite state machine. Each operand has its own input port, made of a 32-bit data word, a valid strobe driven by the sender and an acknowledge driven by the block. A word crosses a port only in a cycle where both the strobe and the acknowledge are high. The product leaves on an output port built the same way. The block collects operand a first and then operand b. It decodes both operands and settles special operands early. For ordinary operands it forms the full significand product with two extra low-order bits, normalises it one bit per cycle, rounds to nearest-even and packs the result.

The packed result is held on the output port until the consumer acknowledges it. Only after that does the block accept a new operand a, so requests never overlap. Latency depends on the data. It is a few cycles for special operands and up to a few hundred cycles when the product falls deep into the subnormal range, but it is always bounded.

Top module: `fmul_handshake`

## Requirements
- R1: A word is transferred on a port only in a cycle where that port's strobe and acknowledge are both high. `aAck` is high only while the block waits for operand a, and `bAck` is high only while it waits for operand b. A strobe raised on the b port while the block waits for a has no effect: `bAck` stays low and no result appears.
- R2: Operand b is acknowledged only after operand a has been taken. Operand a is not acknowledged again until the pending result has been delivered.
- R3: Once `zStb` rises, it stays high and `zData` stays stable until the cycle in which `zAck` is high.
- R4: If either operand is a NaN (exponent field all ones, fraction non-zero), the result is 0xFFC00000.
- R5: Infinity multiplied by zero, in either operand order and with any signs, gives 0xFFC00000.
- R6: Infinity multiplied by a non-zero finite value, or by another infinity, gives infinity. Zero multiplied by a finite value gives zero. In both cases the sign bit (bit 31) is the XOR of the operand signs.
- R7: For finite non-zero operands with a normal, in-range result, the result is the exact product rounded to nearest, with ties going to an even significand.
- R8: Subnormal operands (exponent field zero, fraction non-zero) are accepted, and subnormal results are produced with gradual underflow. This includes products that underflow to a signed zero. Every request completes within a bounded number of cycles, including two subnormal operands.
- R9: When rounding increments a significand that is all ones, the carry moves into the exponent. The result is the next power of two, for example 0x3FFFFFFE × 0x3F800001 = 0x40000000.
- R10: A rounded result whose exponent exceeds the largest finite exponent gives infinity with the XOR sign.
- R11: A synchronous reset returns the block to waiting for operand a, with `bAck` and `zStb` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aData | input | 32 | Operand a word |
| aStb | input | 1 | Operand a valid |
| aAck | output | 1 | Block ready to take operand a |
| bData | input | 32 | Operand b word |
| bStb | input | 1 | Operand b valid |
| bAck | output | 1 | Block ready to take operand b |
| zData | output | 32 | Product word |
| zStb | output | 1 | Product valid |
| zAck | input | 1 | Consumer takes the product |

## Verification
The directed cases target the corners most likely to be wrong:
- Infinity times zero in both orders. A design that tests only for infinity returns infinity here.
- Two subnormal operands. A normalisation loop with a wrong stop condition never finishes on this pair.
- Exact ties on subnormal results. Rounding that ignores the even rule gives an off-by-one last bit.
- An all-ones significand that rounds up. A short all-ones compare leaves the exponent one too small.

The random vectors mix normal, extreme-exponent, subnormal and special operands, with varying delays before the result is acknowledged. They are checked against a bench model that rounds by integer remainder comparison. The handshake checks confirm that a stray b strobe and a long-held result change nothing at the ports.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN   = 1 - BIAS;
  localparam int EMAX   = BIAS;
  localparam int EXP_IW = EXP_W + 2;
  localparam int PROD_W = 2 * SIG_W + 2;
  localparam int LAT_MAX = 2 * PROD_W + 2 * BIAS + 16;

  typedef enum logic [3:0] {
    S_WAIT_A, S_WAIT_B, S_UNPACK, S_SPECIAL, S_MULT,
    S_NORM_L, S_NORM_R, S_ROUND, S_PACK, S_OUT
  } state_t;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic unpack;
    logic special;
    logic mult;
    logic shiftL;
    logic shiftR;
    logic round;
    logic pack;
  } ctrl_t;
endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
  import fmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  aStb,
  input  logic  bStb,
  input  logic  zAck,
  input  logic  specialHit,
  input  logic  needLeft,
  input  logic  needRight,
  output logic  aAck,
  output logic  bAck,
  output logic  zStb,
  output ctrl_t ctl
);
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_WAIT_A;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      S_WAIT_A: if (aStb) begin ctl.loadA = 1'b1; stateNext = S_WAIT_B; end
      S_WAIT_B: if (bStb) begin ctl.loadB = 1'b1; stateNext = S_UNPACK; end
      S_UNPACK: begin ctl.unpack = 1'b1; stateNext = S_SPECIAL; end
      S_SPECIAL: begin
        ctl.special = 1'b1;
        stateNext = specialHit ? S_OUT : S_MULT;
      end
      S_MULT: begin ctl.mult = 1'b1; stateNext = S_NORM_L; end
      S_NORM_L: if (needLeft) ctl.shiftL = 1'b1; else stateNext = S_NORM_R;
      S_NORM_R: if (needRight) ctl.shiftR = 1'b1; else stateNext = S_ROUND;
      S_ROUND: begin ctl.round = 1'b1; stateNext = S_PACK; end
      S_PACK: begin ctl.pack = 1'b1; stateNext = S_OUT; end
      S_OUT: if (zAck) stateNext = S_WAIT_A;
      default: stateNext = S_WAIT_A;
    endcase
  end

  assign aAck = (state == S_WAIT_A);
  assign bAck = (state == S_WAIT_B);
  assign zStb = (state == S_OUT);

  // Cycles spent computing one request; bounded for every operand pair
  logic [15:0] busyCnt;
  always_ff @(posedge clk) begin
    if (rst || aAck || bAck || zStb) busyCnt <= '0;
    else                             busyCnt <= busyCnt + 16'd1;
  end

  assert_ports_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({aAck, bAck, zStb}));

  assert_b_after_a_R2: assert property (@(posedge clk) disable iff (rst)
    (aStb && aAck) |=> (bAck && !aAck));

  assert_bounded_latency_R8: assert property (@(posedge clk) disable iff (rst)
    busyCnt < 16'(LAT_MAX));

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (aAck && !bAck && !zStb));
endmodule

// File: rtl/fmul_datapath.sv
module fmul_datapath
  import fmul_pkg::*;
(
  input  logic              clk,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  output logic              specialHit,
  output logic              needLeft,
  output logic              needRight,
  output logic [WORD_W-1:0] zData
);
  localparam logic signed [EXP_IW-1:0] EMIN_I = EXP_IW'(EMIN);
  localparam logic signed [EXP_IW-1:0] EMAX_I = EXP_IW'(EMAX);
  localparam logic signed [EXP_IW-1:0] BIAS_I = EXP_IW'(BIAS);
  localparam logic signed [EXP_IW-1:0] ONE_I  = EXP_IW'(1);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam int LOW_W = PROD_W - SIG_W - 2;

  logic [WORD_W-1:0] aWord, bWord;
  logic [SIG_W-1:0]  aSig, bSig, zSig;
  logic signed [EXP_IW-1:0] aExp, bExp, zExp;
  logic [PROD_W-1:0] prod;
  logic              lostBits;

  // Operand classification straight from the captured words
  logic [EXP_W-1:0] aEf, bEf;
  logic aExpMax, bExpMax, aExpZero, bExpZero, aFracZero, bFracZero;
  logic aNan, bNan, aInf, bInf, aZero, bZero, zSign;
  assign aEf = aWord[WORD_W-2:FRAC_W];
  assign bEf = bWord[WORD_W-2:FRAC_W];
  assign aExpMax = &aEf;
  assign bExpMax = &bEf;
  assign aExpZero = ~|aEf;
  assign bExpZero = ~|bEf;
  assign aFracZero = ~|aWord[FRAC_W-1:0];
  assign bFracZero = ~|bWord[FRAC_W-1:0];
  assign aNan = aExpMax & ~aFracZero;
  assign bNan = bExpMax & ~bFracZero;
  assign aInf = aExpMax & aFracZero;
  assign bInf = bExpMax & bFracZero;
  assign aZero = aExpZero & aFracZero;
  assign bZero = bExpZero & bFracZero;
  assign zSign = aWord[WORD_W-1] ^ bWord[WORD_W-1];
  assign specialHit = aNan | bNan | aInf | bInf | aZero | bZero;

  logic [WORD_W-1:0] specialWord;
  always_comb begin
    if (aNan || bNan || (aInf && bZero) || (bInf && aZero)) specialWord = QNAN;
    else if (aInf || bInf) specialWord = {zSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else                   specialWord = {zSign, {(WORD_W-1){1'b0}}};
  end

  // Significand product, rounding view and packing view
  logic [2*SIG_W-1:0] sigProd;
  assign sigProd = {{SIG_W{1'b0}}, aSig} * {{SIG_W{1'b0}}, bSig};

  logic [SIG_W-1:0] topSig;
  logic guardBit, roundBit, stickyBit, roundUp;
  assign topSig    = prod[PROD_W-1 -: SIG_W];
  assign guardBit  = prod[PROD_W-SIG_W-1];
  assign roundBit  = prod[PROD_W-SIG_W-2];
  assign stickyBit = (|prod[LOW_W-1:0]) | lostBits;
  assign roundUp   = guardBit & (roundBit | stickyBit | topSig[0]);

  assign needLeft  = !prod[PROD_W-1] && (zExp > EMIN_I);
  assign needRight = zExp < EMIN_I;

  logic signed [EXP_IW-1:0] biasedExp;
  logic [EXP_W-1:0] packExp;
  assign biasedExp = zExp + BIAS_I;
  assign packExp = (zExp == EMIN_I && !zSig[SIG_W-1]) ? '0 : biasedExp[EXP_W-1:0];

  always_ff @(posedge clk) begin
    if (ctl.loadA) aWord <= aIn;
    if (ctl.loadB) bWord <= bIn;
    if (ctl.unpack) begin
      aSig <= {~aExpZero, aWord[FRAC_W-1:0]};
      bSig <= {~bExpZero, bWord[FRAC_W-1:0]};
      aExp <= aExpZero ? EMIN_I : $signed({2'b00, aEf}) - BIAS_I;
      bExp <= bExpZero ? EMIN_I : $signed({2'b00, bEf}) - BIAS_I;
    end
    if (ctl.special && specialHit) zData <= specialWord;
    if (ctl.mult) begin
      prod     <= {sigProd, 2'b00};
      zExp     <= aExp + bExp + ONE_I;
      lostBits <= 1'b0;
    end
    if (ctl.shiftL) begin
      prod <= prod << 1;
      zExp <= zExp - ONE_I;
    end
    if (ctl.shiftR) begin
      prod     <= prod >> 1;
      lostBits <= lostBits | prod[0];
      zExp     <= zExp + ONE_I;
    end
    if (ctl.round) begin
      zSig <= roundUp ? topSig + SIG_W'(1) : topSig;
      if (roundUp && (&topSig)) zExp <= zExp + ONE_I;
    end
    if (ctl.pack) begin
      if (zExp > EMAX_I) zData <= {zSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else               zData <= {zSign, packExp, zSig[FRAC_W-1:0]};
    end
  end

  // After the right-shift phase the exponent never sits below the floor
  assert_exp_floor_R8: assert property (@(posedge clk)
    ctl.round |-> (zExp >= EMIN_I));
endmodule

// File: rtl/fmul_handshake.sv
module fmul_handshake
  import fmul_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] aData,
  input  logic        aStb,
  output logic        aAck,
  input  logic [31:0] bData,
  input  logic        bStb,
  output logic        bAck,
  output logic [31:0] zData,
  output logic        zStb,
  input  logic        zAck
);
  ctrl_t ctl;
  logic  specialHit, needLeft, needRight;

  fmul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .aStb(aStb), .bStb(bStb), .zAck(zAck),
    .specialHit(specialHit), .needLeft(needLeft), .needRight(needRight),
    .aAck(aAck), .bAck(bAck), .zStb(zStb), .ctl(ctl)
  );

  fmul_datapath u_dp (
    .clk(clk), .ctl(ctl), .aIn(aData), .bIn(bData),
    .specialHit(specialHit), .needLeft(needLeft), .needRight(needRight),
    .zData(zData)
  );

  assert_result_held_R3: assert property (@(posedge clk) disable iff (rst)
    (zStb && !zAck) |=> (zStb && $stable(zData)));

  assert_no_new_a_while_pending_R2: assert property (@(posedge clk) disable iff (rst)
    zStb |-> !aAck);
endmodule

// File: tb/tb_fmul_handshake.sv
module tb_fmul_handshake;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 2000;

  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] aData = '0, bData = '0;
  logic aStb = 1'b0, bStb = 1'b0, zAck = 1'b0;
  logic aAck, bAck, zStb;
  logic [31:0] zData;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmul_handshake dut (
    .clk(clk), .rst(rst), .aData(aData), .aStb(aStb), .aAck(aAck),
    .bData(bData), .bStb(bStb), .bAck(bAck),
    .zData(zData), .zStb(zStb), .zAck(zAck)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Independent model: integer product, remainder-based nearest-even rounding
  function automatic logic [31:0] refMul(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, L, sh, be;
    logic [22:0] fa, fb;
    longint unsigned ma, mb, p, m, rem, half;
    s = a[31] ^ b[31];
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = a[22:0]; fb = b[22:0];
    if ((ea == 255 && fa != 0) || (eb == 255 && fb != 0)) return 32'hFFC00000;
    if ((ea == 255 && eb == 0 && fb == 0) || (eb == 255 && ea == 0 && fa == 0)) return 32'hFFC00000;
    if (ea == 255 || eb == 255) return {s, 8'hFF, 23'h0};
    if ((ea == 0 && fa == 0) || (eb == 0 && fb == 0)) return {s, 31'h0};
    ma = (ea != 0) ? (64'h800000 | 64'(fa)) : 64'(fa);
    mb = (eb != 0) ? (64'h800000 | 64'(fb)) : 64'(fb);
    if (ea == 0) ea = 1;
    if (eb == 0) eb = 1;
    p = ma * mb;
    L = 0;
    for (int i = 0; i < 48; i++) if (p[i]) L = i;
    sh = L - 23;
    if (151 - ea - eb > sh) sh = 151 - ea - eb;
    if (sh <= 0) m = p << (-sh);
    else if (sh >= 50) m = 0;
    else begin
      m = p >> sh;
      rem = p & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && m[0])) m = m + 64'd1;
    end
    be = sh + ea + eb - 150;
    if (m == 64'h1000000) begin m = m >> 1; be = be + 1; end
    if (be >= 255) return {s, 8'hFF, 23'h0};
    if (m < 64'h800000) return {s, 8'h00, m[22:0]};
    return {s, be[7:0], m[22:0]};
  endfunction

  function automatic logic [31:0] randOp();
    int cls;
    logic [7:0] e;
    logic [22:0] f;
    cls = int'($urandom % 16);
    f = 23'($urandom);
    case (cls)
      0: begin e = 8'd0; f = '0; end
      1: e = 8'hFF;
      2: begin e = 8'hFF; f = '0; end
      3, 4: begin e = 8'd0; if (f == 0) f = 23'd1; end
      5, 6: e = 8'(1 + $urandom % 60);
      7, 8: e = 8'(200 + $urandom % 55);
      9: begin e = 8'(120 + $urandom % 15); f = (($urandom % 2) == 0) ? 23'h7FFFFF : 23'h000001; end
      default: e = 8'(100 + $urandom % 55);
    endcase
    return {1'($urandom), e, f};
  endfunction

  // One request; holdCycles delays the result acknowledge
  task automatic runVec(input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp,
                        input string req, input int holdCycles);
    int cnt;
    logic [31:0] first;
    @(negedge clk);
    aData = a; aStb = 1'b1;
    cnt = 0;
    while (!aAck && cnt < WAIT_LIMIT) begin @(negedge clk); cnt++; end
    @(negedge clk);
    aStb = 1'b0;
    bData = b; bStb = 1'b1;
    cnt = 0;
    while (!bAck && cnt < WAIT_LIMIT) begin @(negedge clk); cnt++; end
    @(negedge clk);
    bStb = 1'b0;
    cnt = 0;
    while (!zStb && cnt < WAIT_LIMIT) begin @(negedge clk); cnt++; end
    if (!zStb) begin
      checks++; fails++;
      $display("FAIL R8 no result for %h x %h: got no strobe expected strobe", a, b);
      return;
    end
    first = zData;
    for (int i = 0; i < holdCycles; i++) begin
      @(negedge clk);
      check("R3", {zStb, aAck, zData[29:0]}, {1'b1, 1'b0, first[29:0]}, "held result");
      check("R3", zData, first, "held word");
    end
    check(req, zData, exp, $sformatf("%h x %h", a, b));
    zAck = 1'b1;
    @(negedge clk);
    zAck = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11", {29'd0, aAck, bAck, zStb}, 32'b100, "reset ack/strobe");

    // R1: a b strobe while waiting for a is ignored
    bData = 32'h3F800000; bStb = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {30'd0, bAck, zStb}, 32'd0, "stray b strobe");
    bStb = 1'b0;

    // R2: after a is taken, b is requested and a is not
    @(negedge clk);
    aData = 32'h40000000; aStb = 1'b1;
    @(negedge clk);
    aStb = 1'b0;
    check("R2", {30'd0, aAck, bAck}, 32'b01, "after a taken");
    bData = 32'h40400000; bStb = 1'b1;
    @(negedge clk);
    bStb = 1'b0;
    while (!zStb) @(negedge clk);
    check("R2", {31'd0, aAck}, 32'd0, "a blocked while result pending");
    check("R7", zData, 32'h40C00000, "2 x 3");
    zAck = 1'b1; @(negedge clk); zAck = 1'b0;
    check("R1", {29'd0, aAck, bAck, zStb}, 32'b100, "back to waiting for a");

    runVec(32'h3F800000, 32'h3F800000, 32'h3F800000, "R7", 0);
    runVec(32'hC0000000, 32'h40400000, 32'hC0C00000, "R7", 2);
    runVec(32'h3FC00000, 32'h3FC00000, 32'h40100000, "R7", 0);
    runVec(32'h7FC00001, 32'h3F800000, 32'hFFC00000, "R4", 0);
    runVec(32'h3F800000, 32'hFF800001, 32'hFFC00000, "R4", 0);
    runVec(32'h7F800000, 32'h00000000, 32'hFFC00000, "R5", 0);
    runVec(32'h80000000, 32'hFF800000, 32'hFFC00000, "R5", 0);
    runVec(32'h7F800000, 32'hC0000000, 32'hFF800000, "R6", 0);
    runVec(32'hFF800000, 32'hFF800000, 32'h7F800000, "R6", 0);
    runVec(32'h00000000, 32'hC0400000, 32'h80000000, "R6", 0);
    runVec(32'h00800000, 32'h3F000000, 32'h00400000, "R8", 0);
    runVec(32'h00400000, 32'h40000000, 32'h00800000, "R8", 0);
    runVec(32'h00000001, 32'h3F000000, 32'h00000000, "R8", 0);
    runVec(32'h00000003, 32'h3F000000, 32'h00000002, "R8", 0);
    runVec(32'h005EC72E, 32'h001FDDEB, 32'h00000000, "R8", 0);
    runVec(32'h3FFFFFFE, 32'h3F800001, 32'h40000000, "R9", 0);
    runVec(32'h7F7FFFFF, 32'h40000000, 32'h7F800000, "R10", 0);
    runVec(32'hFF000000, 32'h7F000000, 32'hFF800000, "R10", 0);
    runVec(32'h3F7FFFFF, 32'h3F800001, refMul(32'h3F7FFFFF, 32'h3F800001), "R7", 0);

    for (int n = 0; n < 400; n++) begin
      ra = randOp();
      rb = randOp();
      runVec(ra, rb, refMul(ra, rb), "R7", int'($urandom % 3));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule